// File: doc/BRIEF.md
# Single/Dual Address Transfer Channel

This block is one channel of a direct memory transfer engine that masters an external bus. Software loads a source address, a destination address, a transfer count and a control word through a small register port. Setting the enable bit arms the channel. Each time the request input is high, the channel performs one transfer. When the count runs out, the channel stops on its own and clears its enable bit.

Two modes are available. In dual address mode, a transfer takes two bus cycles. The first reads from the source address and the channel latches the data. The second writes that data to the destination address. In single address mode, an active-low acknowledge strobe selects the peripheral while the channel drives only the memory address, so the datum moves directly between peripheral and memory in one bus cycle. The direction bit chooses the memory side:
- With direction 0, memory at the source address is read and the peripheral takes the data.
- With direction 1, the peripheral drives the data and memory at the destination address is written.

An optional end strobe marks the bus cycle that carries the last datum.

The control state machine has four states: `IDLE`, `RD_PH` (dual read cycle), `WR_PH` (dual write cycle) and `ONE_PH` (single address cycle). Its transitions are:
- IDLE→RD_PH or IDLE→ONE_PH, when the channel is enabled, the count is nonzero and the request is high.
- RD_PH→WR_PH, always.
- WR_PH→RD_PH and ONE_PH→ONE_PH, when more transfers remain and the request is still high at the end of the transfer.
- WR_PH→IDLE and ONE_PH→IDLE, otherwise.

Top module: `xch_top`

## Requirements
- R1: In dual address mode, each transfer is a read cycle (`bus_rd`=1) at the source address. It is followed in the very next clock by a write cycle (`bus_wr`=1) at the destination address, and `bus_wdata` equals the `bus_rdata` sampled during the read cycle.
- R2: In single address mode, each transfer is exactly one clock with `bus_ack_n`=0 and exactly one of `bus_rd`/`bus_wr` high.
- R3: In single address mode with direction 0 (control bit 2), `bus_addr` is the source register and `bus_rd` is high.
- R4: In single address mode with direction 1, `bus_addr` is the destination register and `bus_wr` is high.
- R5: In single address mode, the address register that the direction does not use keeps its value across the whole run.
- R6: `bus_ack_n` is 1 whenever the channel is idle or in dual address mode (control bit 1 = 0).
- R7: With end enable (control bit 3) set, `xfer_end` is high for exactly one clock, namely the bus cycle that carries the last datum (the write cycle in dual mode). With end enable clear, it never rises.
- R8: The count register (select 2) decreases by one per completed transfer. When it reaches zero, the channel returns to idle and clears enable (control bit 0).
- R9: After each transfer, every address register in use advances by 1, or by 2 when the size bit (control bit 4) is set.
- R10: A transfer starts only when enable is set, the count is nonzero and `dreq` is high. `dreq` is sampled again at the end of each transfer, and a low value there pauses the channel.
- R11: After reset, all four registers read 0, `bus_rd`, `bus_wr` and `xfer_end` are 0, and `bus_ack_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Read data of the selected register |
| dreq | input | 1 | Transfer request |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_ack_n | output | 1 | Active-low peripheral acknowledge |
| bus_rdata | input | DW | Bus read data |
| bus_wdata | output | DW | Bus write data (dual mode) |
| bus_wide | output | 1 | Transfer size: 1 selects two bytes |
| xfer_end | output | 1 | Last-transfer strobe |

## Verification
Assertions check, on every cycle:
- that a dual read cycle is always followed by its write cycle;
- that the acknowledge is never low outside single address mode and always comes with one strobe;
- that the end strobe appears only while one transfer remains;
- that the count and the active address advance by the right step;
- that enable drops when the count empties;
- that no transfer starts without a request.

The directed scenarios are needed for the rest:
- the exact address sequence;
- the data carried from read to write;
- the single end pulse;
- the untouched unused register;
- pausing on a dropped request;
- the refusal to start with a zero count.

// File: rtl/xch_pkg.sv
package xch_pkg;

    typedef enum logic [1:0] {
        IDLE   = 2'd0,
        RD_PH  = 2'd1,
        WR_PH  = 2'd2,
        ONE_PH = 2'd3
    } xch_state_e;

    // control word, en at bit 0
    typedef struct packed {
        logic wide;
        logic end_en;
        logic dir;
        logic single;
        logic en;
    } xch_ctrl_t;

    localparam int CTRL_W = $bits(xch_ctrl_t);

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/xch_regs.sv
module xch_regs
    import xch_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          adv_src,
    input  logic          adv_dst,
    input  logic          dec_cnt,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output xch_ctrl_t     ctrl_q
);

    logic [AW-1:0] step;
    assign step = ctrl_q.wide ? AW'(2) : AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_SRC:  src_q  <= cfg_wdata;
                SEL_DST:  dst_q  <= cfg_wdata;
                SEL_CNT:  cnt_q  <= cfg_wdata[CW-1:0];
                SEL_CTRL: ctrl_q <= xch_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            endcase
        end else begin
            if (adv_src) src_q <= src_q + step;
            if (adv_dst) dst_q <= dst_q + step;
            if (dec_cnt) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) ctrl_q.en <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (cfg_sel)
            SEL_SRC:  cfg_rdata = src_q;
            SEL_DST:  cfg_rdata = dst_q;
            SEL_CNT:  cfg_rdata = AW'(cnt_q);
            SEL_CTRL: cfg_rdata = AW'(ctrl_q);
        endcase
    end

    // R8: count falls by one per completed transfer
    a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_cnt && !cfg_we) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8: enable drops as the count empties
    a_r8_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_cnt && !cfg_we && cnt_q == CW'(1)) |=> !ctrl_q.en);

    // R9: active source address moves by the transfer size
    a_r9_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_src && !cfg_we) |=> (src_q == $past(src_q) + $past(step)));

endmodule

// File: rtl/xch_fsm.sv
module xch_fsm
    import xch_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xch_ctrl_t     ctrl,
    input  logic          cnt_nz,
    input  logic          cnt_last,
    input  logic          dreq,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_ack_n,
    output logic [DW-1:0] bus_wdata,
    output logic          xfer_end,
    output logic          adv_src,
    output logic          adv_dst,
    output logic          dec_cnt
);

    xch_state_e state_q, state_d;
    logic [DW-1:0] hold_q;
    logic go, more;

    assign go   = ctrl.en && cnt_nz && dreq;
    assign more = ctrl.en && !cnt_last && dreq;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:   if (go) state_d = ctrl.single ? ONE_PH : RD_PH;
            RD_PH:  state_d = WR_PH;
            WR_PH:  state_d = more ? RD_PH : IDLE;
            ONE_PH: state_d = more ? ONE_PH : IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RD_PH) hold_q <= bus_rdata;
        end
    end

    always_comb begin
        bus_addr  = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_ack_n = 1'b1;
        xfer_end  = 1'b0;
        adv_src   = 1'b0;
        adv_dst   = 1'b0;
        dec_cnt   = 1'b0;
        unique case (state_q)
            IDLE: ;
            RD_PH: begin
                bus_addr = src;
                bus_rd   = 1'b1;
                adv_src  = 1'b1;
            end
            WR_PH: begin
                bus_addr = dst;
                bus_wr   = 1'b1;
                adv_dst  = 1'b1;
                dec_cnt  = 1'b1;
                xfer_end = ctrl.end_en && cnt_last;
            end
            ONE_PH: begin
                bus_ack_n = 1'b0;
                bus_addr  = ctrl.dir ? dst : src;
                bus_rd    = !ctrl.dir;
                bus_wr    = ctrl.dir;
                adv_src   = !ctrl.dir;
                adv_dst   = ctrl.dir;
                dec_cnt   = 1'b1;
                xfer_end  = ctrl.end_en && cnt_last;
            end
        endcase
    end

    assign bus_wdata = hold_q;

    // R1: a dual read cycle is followed at once by its write cycle
    a_r1_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ack_n) |=> (bus_wr && bus_wdata == $past(bus_rdata)));

endmodule

// File: rtl/xch_top.sv
module xch_top
    import xch_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          dreq,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_ack_n,
    input  logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wide,
    output logic          xfer_end
);

    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q;
    xch_ctrl_t     ctrl_q;
    logic          adv_src, adv_dst, dec_cnt;

    xch_regs #(.AW(AW), .CW(CW)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .adv_src(adv_src), .adv_dst(adv_dst), .dec_cnt(dec_cnt),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .ctrl_q(ctrl_q)
    );

    xch_fsm #(.AW(AW), .DW(DW)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl(ctrl_q), .cnt_nz(cnt_q != '0), .cnt_last(cnt_q == CW'(1)),
        .dreq(dreq), .src(src_q), .dst(dst_q), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack_n(bus_ack_n),
        .bus_wdata(bus_wdata), .xfer_end(xfer_end),
        .adv_src(adv_src), .adv_dst(adv_dst), .dec_cnt(dec_cnt)
    );

    assign bus_wide = ctrl_q.wide;

    // R6: acknowledge stays high outside single address mode
    a_r6_ack_dual_high: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.single |-> bus_ack_n);

    // R2: an acknowledged cycle carries exactly one strobe
    a_r2_ack_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack_n |-> $countones({bus_rd, bus_wr}) == 1);

    // R7: end strobe only while one transfer remains
    a_r7_end_last: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |-> (cnt_q == CW'(1) && ctrl_q.end_en));

    // R10: no bus activity begins without a sampled request
    a_r10_start_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd || bus_wr) |-> $past(dreq));

endmodule

// File: tb/test_xch_top.sv
module test_xch_top;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          dreq = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_rd, bus_wr, bus_ack_n, bus_wide, xfer_end;
    logic [DW-1:0] bus_rdata = '0;
    logic [DW-1:0] bus_wdata;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    xch_top #(.AW(AW), .DW(DW), .CW(CW)) i_xch_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dreq(dreq), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_ack_n(bus_ack_n), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
        .bus_wide(bus_wide), .xfer_end(xfer_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [AW-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [AW-1:0] val);
        cfg_sel = sel;
        #1 val = cfg_rdata;
    endtask

    function automatic logic [AW-1:0] ctrl_word(input bit wide, input bit end_en,
                                                input bit dir, input bit single, input bit en);
        return AW'({wide, end_en, dir, single, en});
    endfunction

    task automatic t_reset;
        logic [AW-1:0] v;
        for (int s = 0; s < 4; s++) begin
            rd_reg(2'(s), v);
            chk(v == 0, "R11 reg reset", int'(v), 0);
        end
        chk(!bus_rd && !bus_wr && bus_ack_n && !xfer_end, "R11 bus idle",
            int'({bus_rd, bus_wr, bus_ack_n, xfer_end}), 2);
    endtask

    // one complete run with the request held high
    task automatic t_run(input bit single, input bit dir, input bit wide, input bit end_en,
                         input int n, input logic [AW-1:0] src, input logic [AW-1:0] dst);
        int k = 0;
        int ends = 0;
        int ack_lo = 0;
        bit want_wr = 0;
        int step = wide ? 2 : 1;
        logic [DW-1:0] held = '0;
        logic [AW-1:0] v;
        wr_reg(SEL_SRC_T, src);
        wr_reg(SEL_DST_T, dst);
        wr_reg(2'd2, AW'(n));
        dreq = 1'b1;
        wr_reg(2'd3, ctrl_word(wide, end_en, dir, single, 1'b1));
        for (int c = 0; c < 2 * n + 8; c++) begin
            if (xfer_end) ends++;
            if (!bus_ack_n) ack_lo++;
            if (single) begin
                if (bus_rd || bus_wr) begin
                    chk(!bus_ack_n, "R2 ack low", int'(bus_ack_n), 0);
                    if (!dir) begin
                        chk(bus_rd && !bus_wr, "R3 read strobe", int'({bus_rd, bus_wr}), 2);
                        chk(bus_addr == src + AW'(k * step), "R3/R9 src addr",
                            int'(bus_addr), int'(src + AW'(k * step)));
                    end else begin
                        chk(bus_wr && !bus_rd, "R4 write strobe", int'({bus_rd, bus_wr}), 1);
                        chk(bus_addr == dst + AW'(k * step), "R4/R9 dst addr",
                            int'(bus_addr), int'(dst + AW'(k * step)));
                    end
                    chk(xfer_end == (end_en && k == n - 1), "R7 end timing",
                        int'(xfer_end), int'(end_en && k == n - 1));
                    k++;
                end
            end else begin
                if (want_wr) begin
                    chk(bus_wr && !bus_rd, "R1 write follows read", int'({bus_rd, bus_wr}), 1);
                    chk(bus_addr == dst + AW'(k * step), "R1/R9 dst addr",
                        int'(bus_addr), int'(dst + AW'(k * step)));
                    chk(bus_wdata == held, "R1 data carried", int'(bus_wdata), int'(held));
                    chk(xfer_end == (end_en && k == n - 1), "R7 end timing",
                        int'(xfer_end), int'(end_en && k == n - 1));
                    k++;
                    want_wr = 0;
                end else if (bus_rd) begin
                    chk(bus_addr == src + AW'(k * step), "R1/R9 src addr",
                        int'(bus_addr), int'(src + AW'(k * step)));
                    chk(!xfer_end, "R7 no end on read", int'(xfer_end), 0);
                    held = DW'(bus_addr) ^ DW'(16'h5A3C);
                    bus_rdata = held;
                    want_wr = 1;
                end
            end
            @(negedge clk);
        end
        dreq = 1'b0;
        chk(k == n, "R8 transfer count", k, n);
        chk(ends == (end_en ? 1 : 0), "R7 end pulses", ends, end_en ? 1 : 0);
        if (!single) chk(ack_lo == 0, "R6 ack high in dual", ack_lo, 0);
        rd_reg(2'd2, v);
        chk(v == 0, "R8 count empty", int'(v), 0);
        rd_reg(2'd3, v);
        chk(v[0] == 1'b0, "R8 enable cleared", int'(v[0]), 0);
        chk(bus_ack_n && !bus_rd && !bus_wr, "R6 idle bus", int'({bus_ack_n, bus_rd, bus_wr}), 4);
        rd_reg(2'd0, v);
        if (single && dir)
            chk(v == src, "R5 src untouched", int'(v), int'(src));
        else
            chk(v == src + AW'(n * step), "R9 src final", int'(v), int'(src + AW'(n * step)));
        rd_reg(2'd1, v);
        if (single && !dir)
            chk(v == dst, "R5 dst untouched", int'(v), int'(dst));
        else
            chk(v == dst + AW'(n * step), "R9 dst final", int'(v), int'(dst + AW'(n * step)));
    endtask

    localparam logic [1:0] SEL_SRC_T = 2'd0;
    localparam logic [1:0] SEL_DST_T = 2'd1;

    // R10: request gating, one transfer per sampled request
    task automatic t_pause;
        logic [AW-1:0] v;
        int act = 0;
        wr_reg(2'd0, 16'h0300);
        wr_reg(2'd2, 16'd3);
        dreq = 1'b0;
        wr_reg(2'd3, ctrl_word(0, 0, 0, 1, 1));
        for (int c = 0; c < 5; c++) begin
            if (bus_rd || bus_wr) act++;
            @(negedge clk);
        end
        chk(act == 0, "R10 no request no cycle", act, 0);
        dreq = 1'b1;
        @(negedge clk);
        chk(bus_rd && !bus_ack_n && bus_addr == 16'h0300, "R10 start on request",
            int'(bus_addr), 16'h0300);
        dreq = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (bus_rd || bus_wr) act++;
        end
        chk(act == 0, "R10 paused after low request", act, 0);
        rd_reg(2'd2, v);
        chk(v == 2, "R10 count after one transfer", int'(v), 2);
        wr_reg(2'd3, ctrl_word(0, 0, 0, 1, 0));
    endtask

    // R10: zero count never starts
    task automatic t_zero;
        logic [AW-1:0] v;
        int act = 0;
        wr_reg(2'd2, 16'd0);
        dreq = 1'b1;
        wr_reg(2'd3, ctrl_word(0, 1, 0, 0, 1));
        for (int c = 0; c < 6; c++) begin
            if (bus_rd || bus_wr || xfer_end) act++;
            @(negedge clk);
        end
        dreq = 1'b0;
        chk(act == 0, "R10 zero count idle", act, 0);
        rd_reg(2'd0, v);
        chk(v == 16'h0303 - 16'h0003 + 16'h0001, "R10 src not moved", int'(v), 16'h0301);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run(0, 0, 0, 1, 3, 16'h0100, 16'h0200);
        t_run(0, 0, 1, 0, 2, 16'h1000, 16'h2000);
        t_run(1, 0, 0, 0, 4, 16'h0040, 16'h0F00);
        t_run(1, 1, 1, 1, 3, 16'h0A00, 16'h0080);
        t_pause();
        t_zero();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule